// File: doc/BRIEF.md
# Serial Management Frame Controller

This block runs one management transaction on a two-wire station management bus (clock MDC, bidirectional data MDIO). Software hands it a single 32-bit frame word that carries the start code, the opcode, the PHY address, the register address, a two-bit turnaround field and a 16-bit data field. The block sends a run of ones as a preamble, then shifts the frame out MSB first. For a read it releases the data line from the turnaround onward and shifts the bits returned by the PHY into the low half of the same word. Completion is shown by the block setting the low turnaround bit (bit 16) of that word. Software writes that bit as 0 and polls for it.

Two management ports are provided. A select input latched with the frame routes the transaction to the external port (index 1) or to the internal port (index 0). While a port is idle its data line is pulled high by a live PHY, so the level seen there is reported as a presence flag. Frame transactions are accepted only while the bit-bang mode input is low. The MDC half period is a parameter counted in system clocks.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: During reset `frame_q`, `busy`, `mdc`, `mdio_oe` and `phy_present` are all 0, and `mdio_o` is all ones.
- R2: A write (`wr_en` high) is accepted on a clock edge where `busy` is 0 and `bitbang_mode` is 0. `frame_q` takes `wr_data` and `busy` is 1 from the next cycle.
- R3: While busy, MDC runs 64 periods of `2*HALF_DIV` clocks, with a low phase of `HALF_DIV` clocks followed by a high phase of `HALF_DIV` clocks. When idle, MDC is 0.
- R4: The selected port drives 1 during the first 32 MDC periods (slots 0..31).
- R5: In slots 32..63 the selected port drives frame bit `63-slot`, so bit 31 is sent first. Each value stays unchanged over its whole slot.
- R6: A frame with opcode bits [29:28] = 2'b10 is a read. For a read, the output enable of the selected port is 0 from slot 46 (the turnaround) through slot 63. For every other opcode it stays 1 for all 64 slots.
- R7: For a read, the data line of the selected port is sampled at each MDC rising edge in slots 48..63. Each sample is shifted into `frame_q[15:0]` from the LSB end, so the first sample ends up in bit 15.
- R8: After the last slot, `busy` drops and `frame_q[16]` becomes 1. For a read, `frame_q[31:17]` keeps the value that was written. For a write, the whole word keeps the written value apart from bit 16.
- R9: `phy_sel` = 1 selects port 1 and `phy_sel` = 0 selects port 0, latched when the write is accepted. The other port keeps output enable 0 and output 1.
- R10: A write while `busy` is 1, or while `bitbang_mode` is 1, is ignored. `frame_q` and `busy` are left as they were.
- R11: For each port that is not carrying a transaction, `phy_present[i]` takes the level of `mdio_i[i]` one clock later. It holds its value while that port is carrying a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Frame word write strobe |
| wr_data | input | 32 | Frame word to load |
| phy_sel | input | 1 | Port select: 1 external (port 1), 0 internal (port 0) |
| bitbang_mode | input | 1 | When high, frame writes are ignored |
| frame_q | output | 32 | Frame word; bit 16 set on completion, read data in [15:0] |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_i | input | 2 | Data line input for each port |
| mdio_o | output | 2 | Data line output for each port |
| mdio_oe | output | 2 | Data line output enable for each port |
| phy_present | output | 2 | Idle data line level for each port |

## Verification
A write frame shows that the preamble and every frame bit come out in order with the enable held for all 64 slots. Read frames on both ports, returning 16'h8001, 16'hFFFF and 16'h0000 into data fields preloaded with different patterns, show the release point at the turnaround, the MSB-first capture order, and that no preloaded bit survives. Writes issued during a transaction and while bit-bang mode is set confirm that the command word stays untouched. Pulling one idle port low separates the presence flags of the two ports.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W  = 32;
  localparam int PRE_BITS = 32;
  localparam int SLOTS    = PRE_BITS + FRAME_W;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int TA_SLOT  = PRE_BITS + 14;   // first turnaround slot
  localparam int DAT_SLOT = PRE_BITS + 16;   // first data slot
  localparam logic [1:0] OP_READ = 2'b10;

  function automatic logic is_read(input logic [FRAME_W-1:0] f);
    return f[29:28] == OP_READ;
  endfunction

  // Value driven on the line during a given slot
  function automatic logic slot_value(input logic [FRAME_W-1:0] f,
                                      input logic [SLOT_W-1:0] s);
    if (int'(s) < PRE_BITS) return 1'b1;
    return f[SLOTS-1-int'(s)];
  endfunction

  function automatic logic line_released(input logic rd, input logic [SLOT_W-1:0] s);
    return rd && int'(s) >= TA_SLOT;
  endfunction

  function automatic logic captures(input logic rd, input logic [SLOT_W-1:0] s);
    return rd && int'(s) >= DAT_SLOT;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  output logic                       busy,
  output logic                       mdc,
  output logic [mdio_pkg::SLOT_W-1:0] slot,
  output logic                       rise,
  output logic                       fin
);
  import mdio_pkg::*;
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic          phase_q;
  logic          half_end;

  assign half_end = busy && (div_q == DIV_LAST);
  assign rise     = half_end && !phase_q;
  assign fin      = half_end && phase_q && (int'(slot) == SLOTS - 1);
  assign mdc      = busy && phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      div_q   <= '0;
      phase_q <= 1'b0;
      slot    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        div_q   <= '0;
        phase_q <= 1'b0;
        slot    <= '0;
      end
    end else if (half_end) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (fin) busy <= 1'b0;
        else     slot <= slot + 1'b1;
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assert_rise_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> mdc);
  assert_fin_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!busy && !mdc));
endmodule

// File: rtl/mdio_frame_reg.sv
module mdio_frame_reg (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [mdio_pkg::FRAME_W-1:0] wr_data,
  input  logic                         rise,
  input  logic                         fin,
  input  logic [mdio_pkg::SLOT_W-1:0]  slot,
  input  logic                         sample_bit,
  output logic [mdio_pkg::FRAME_W-1:0] frame
);
  import mdio_pkg::*;
  logic take;
  assign take = rise && captures(is_read(frame), slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame <= '0;
    end else if (load) begin
      frame <= wr_data;
    end else begin
      if (take) frame[15:0] <= {frame[14:0], sample_bit};
      if (fin)  frame[16]   <= 1'b1;
    end
  end

  assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> frame[16]);
  assert_cmd_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(frame[31:17]));
endmodule

// File: rtl/mdio_port_mux.sv
module mdio_port_mux #(
  parameter int NPORT = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    busy,
  input  logic [(NPORT > 1 ? $clog2(NPORT) : 1)-1:0] sel,
  input  logic                                    drive,
  input  logic                                    release_line,
  input  logic [NPORT-1:0]                        mdio_i,
  output logic [NPORT-1:0]                        mdio_o,
  output logic [NPORT-1:0]                        mdio_oe,
  output logic [NPORT-1:0]                        present,
  output logic                                    sample_bit
);
  assign sample_bit = mdio_i[sel];

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic active;
    assign active     = busy && (int'(sel) == i);
    assign mdio_o[i]  = active ? drive : 1'b1;
    assign mdio_oe[i] = active && !release_line;
    always_ff @(posedge clk) begin
      if (!rst_n)       present[i] <= 1'b0;
      else if (!active) present[i] <= mdio_i[i];
    end
  end

  assert_single_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mdio_oe) <= 1);
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        phy_sel,
  input  logic        bitbang_mode,
  output logic [31:0] frame_q,
  output logic        busy,
  output logic        mdc,
  input  logic [1:0]  mdio_i,
  output logic [1:0]  mdio_o,
  output logic [1:0]  mdio_oe,
  output logic [1:0]  phy_present
);
  import mdio_pkg::*;

  logic              load, rise, fin, sample_bit, sel_q;
  logic [SLOT_W-1:0] slot;
  logic              drive, rel;

  assign load  = wr_en && !bitbang_mode && !busy;
  assign drive = slot_value(frame_q, slot);
  assign rel   = line_released(is_read(frame_q), slot);

  always_ff @(posedge clk) begin
    if (!rst_n)    sel_q <= 1'b0;
    else if (load) sel_q <= phy_sel;
  end

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(load), .busy(busy), .mdc(mdc),
    .slot(slot), .rise(rise), .fin(fin)
  );

  mdio_frame_reg u_frame (
    .clk(clk), .rst_n(rst_n), .load(load), .wr_data(wr_data), .rise(rise),
    .fin(fin), .slot(slot), .sample_bit(sample_bit), .frame(frame_q)
  );

  mdio_port_mux #(.NPORT(2)) u_mux (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sel(sel_q), .drive(drive),
    .release_line(rel), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .present(phy_present), .sample_bit(sample_bit)
  );

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bitbang_mode && !busy) |=> (busy && frame_q == $past(wr_data)));
  assert_preamble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(slot) < PRE_BITS) |-> (&mdio_o));
  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_q[29:28] == 2'b10 && int'(slot) >= TA_SLOT) |-> (mdio_oe == 2'b00));
  assert_bitbang_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && bitbang_mode) |=> !busy);
endmodule

// File: tb/sim_mdio_frame_ctrl.sv
module sim_mdio_frame_ctrl;
  localparam int H = 2;
  localparam int TOTAL = 128 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        phy_sel = 1'b0;
  logic        bitbang_mode = 1'b0;
  logic [31:0] frame_q;
  logic        busy, mdc;
  logic [1:0]  mdio_i = 2'b11;
  logic [1:0]  mdio_o, mdio_oe, phy_present;

  mdio_frame_ctrl #(.HALF_DIV(H)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .phy_sel(phy_sel), .bitbang_mode(bitbang_mode), .frame_q(frame_q),
    .busy(busy), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .phy_present(phy_present)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_busy = 0;
  int          m_t = 0;
  logic [31:0] m_frame = '0;
  int          m_sel = 0;
  logic [1:0]  m_present = '0;
  logic [1:0]  absent = '0;
  logic [15:0] phy_word = '0;

  function automatic bit m_read();
    return m_frame[29:28] == 2'b10;
  endfunction

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference update at each edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_frame = '0; m_sel = 0; m_present = '0;
    end else begin
      for (int i = 0; i < 2; i++)
        if (!(m_busy && m_sel == i)) m_present[i] = mdio_i[i];
      if (m_busy) begin
        if ((m_t % (2*H)) == H-1 && m_read() && (m_t / (2*H)) >= 48)
          m_frame[15:0] = {m_frame[14:0], mdio_i[m_sel]};
        if (m_t == TOTAL-1) begin
          m_busy = 0; m_frame[16] = 1'b1;
        end else m_t++;
      end else if (wr_en && !bitbang_mode) begin
        m_busy = 1; m_t = 0; m_frame = wr_data; m_sel = int'(phy_sel);
      end
    end
  end

  // PHY model and idle pull levels
  always @(negedge clk) begin
    #1;
    for (int i = 0; i < 2; i++) begin
      int s;
      s = m_t / (2*H);
      if (m_busy && m_sel == i && m_read() && s >= 48)
        mdio_i[i] = phy_word[63 - s];
      else
        mdio_i[i] = !absent[i];
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [1:0] e_o, e_oe;
      int s;
      s = m_t / (2*H);
      e_o = 2'b11; e_oe = 2'b00;
      if (m_busy) begin
        e_o[m_sel]  = (s < 32) ? 1'b1 : m_frame[63 - s];
        e_oe[m_sel] = !(m_read() && s >= 46);
      end
      check_eq("R2 busy", busy, m_busy);
      check_eq("R3 mdc", mdc, m_busy ? ((m_t / H) % 2) : 0);
      check_eq((m_busy && s < 32) ? "R4 preamble" : "R5 data out", mdio_o, e_o);
      check_eq("R6/R9 enable", mdio_oe, e_oe);
      check_eq("R7 frame", frame_q, m_frame);
      check_eq("R11 present", phy_present, m_present);
    end
  end

  initial begin
    while (!done && cycles < 150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_write(input logic [31:0] d, input logic sel, input logic bb);
    @(negedge clk); #2;
    wr_en = 1'b1; wr_data = d; phy_sel = sel; bitbang_mode = bb;
    @(negedge clk); #2;
    wr_en = 1'b0; bitbang_mode = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] f;
    repeat (3) @(negedge clk);
    check_eq("R1 frame", frame_q, 0);
    check_eq("R1 ctrl", {busy, mdc, mdio_oe, phy_present}, 0);
    check_eq("R1 out", mdio_o, 2'b11);
    @(negedge clk); #2 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // write transaction on internal port, with an ignored write mid-frame
    f = {2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'hA5C3};
    do_write(f, 1'b0, 1'b0);
    check_eq("R2 busy after write", busy, 1);
    repeat (20) @(negedge clk);
    do_write(32'h1234_5678, 1'b1, 1'b0);
    check_eq("R10 busy write", frame_q, f);
    wait_idle();
    check_eq("R8 write done", frame_q, f | 32'h0001_0000);

    // read on external port
    phy_word = 16'h8001;
    f = {2'b01, 2'b10, 5'd1, 5'd2, 2'b10, 16'h0000};
    do_write(f, 1'b1, 1'b0);
    wait_idle();
    check_eq("R7 read 8001", frame_q[15:0], 16'h8001);
    check_eq("R8 read done", frame_q[31:16], f[31:16] | 16'h0001);

    // bit-bang mode blocks frame writes
    do_write(32'hDEAD_BEEF, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check_eq("R10 bitbang", {frame_q, 31'b0, busy}, {f[31:16] | 16'h0001, 16'h8001, 32'h0});

    // absent external PHY
    absent = 2'b10;
    repeat (3) @(negedge clk);
    check_eq("R11 presence", phy_present, 2'b01);
    phy_word = 16'hFFFF;
    f = {2'b01, 2'b10, 5'd31, 5'd31, 2'b10, 16'h1234};
    do_write(f, 1'b0, 1'b0);
    wait_idle();
    check_eq("R7 read FFFF", frame_q[15:0], 16'hFFFF);
    absent = 2'b00;

    phy_word = 16'h0000;
    f = {2'b01, 2'b10, 5'd0, 5'd0, 2'b10, 16'hFFFF};
    do_write(f, 1'b0, 1'b0);
    wait_idle();
    check_eq("R7 read 0000", frame_q[15:0], 16'h0000);
    check_eq("R9 idle outputs", {mdio_oe, mdio_o}, {2'b00, 2'b11});
    repeat (2) @(negedge clk);
    check_eq("R11 presence both", phy_present, 2'b11);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule